// File: doc/BRIEF.md
# Hardware Monitor Limit Status Register

This block watches seven monitored quantities: one supply voltage, four fan tachometer periods and two remote diode temperatures. Each arrives already digitised, together with a one-cycle completion strobe. On each accepted strobe the block stores the reading, compares it with host-programmed limits and records any violation in a sticky status register. Sensor fault flags for the two diodes are recorded in the same way. When a diode reports a fault, a fixed code is stored in place of its measured temperature.

A global run control decides whether strobes are accepted at all. Every status bit has its own enable. While a bit's enable is 0, that bit can never become set. Turning an enable off does not clear an asserted bit straight away. The bit drops at the next accepted update of that channel's reading. A single interrupt output summarises all status bits behind a global interrupt enable. The host reaches every register through a simple synchronous read/write port. A read of a status register clears it.

Top module: `hwmon_limit_status`

## Requirements
- R1: After reset, both status registers, the control register and all readings read 0. The voltage high limit reads 8'hFF, every tachometer minimum reads 16'hFFFF, every diode high limit reads 8'h7F, and irqOut is 0.
- R2: Voltage status (STATUS bit 0) is set by an accepted voltage strobe whose sample is less than or equal to the low limit (address 5), or strictly greater than the high limit (address 6). Both comparisons are unsigned.
- R3: Tachometer i status (STATUS bit 2+i, i = 0..3) is set by an accepted strobe whose 16-bit sample is strictly greater than the minimum formed from {MSB at address 17+2i, LSB at address 16+2i}. Tachometer readings read back as LSB at 8+2i and MSB at 9+2i.
- R4: An accepted diode j strobe (j = 0..1) with diodeFault[j] = 1 sets STATUS bit 6+j and loads that diode's reading (address 24+j) with 8'h80 instead of the sample.
- R5: Diode j over-temperature (STATUS2 at address 3, bit j) is set when the stored reading, taken as signed, is strictly greater than the signed high limit at address 26+j. A faulted reading of 8'h80 never sets it.
- R6: STATUS (address 2) is read-only, and host writes to it change nothing. STATUS bit 1 and ENABLE bit 1 always read 0.
- R7: While enabled, a set status bit stays set through later non-violating updates. A read of STATUS (or STATUS2) returns the current value and then clears that register on the same edge.
- R8: A status bit never goes from 0 to 1 while its ENABLE bit (address 1, same bit layout as STATUS; diode j's enable bit 6+j also gates STATUS2 bit j) is 0.
- R9: A status bit whose enable has been cleared keeps its value until the next accepted update of its own channel, and is cleared by that update. Other channels' bits are unaffected.
- R10: While START (CTRL address 0, bit 0) is 0, measurement strobes are ignored: readings and status bits do not change.
- R11: An accepted update of a disabled diode channel clears both its STATUS fault bit and its STATUS2 over-temperature bit.
- R12: irqOut is 1 exactly when the interrupt enable (CTRL bit 1) is 1 and any bit of STATUS or STATUS2 is 1.
- R13: Read data appears on hostRdData in the cycle after hostRdEn. Unused addresses (7, 28 to 31) read 0. A write to a writable register takes effect at the clock edge on which hostWrEn is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 5 | Host register address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Registered host read data |
| voltStrobe | input | 1 | Voltage measurement complete |
| voltSample | input | 8 | Voltage sample |
| tachStrobe | input | 4 | Per-tachometer measurement complete |
| tachSample | input | 64 | Four 16-bit tachometer periods, tachometer i at bits 16i+15:16i |
| diodeStrobe | input | 2 | Per-diode measurement complete |
| diodeSample | input | 16 | Two 8-bit temperatures, diode j at bits 8j+7:8j |
| diodeFault | input | 2 | Per-diode open/short indication, valid with its strobe |
| irqOut | output | 1 | Gated summary interrupt |

## Verification
The hardest situation to reach is a status bit that is set while its enable is already off and START is 0. It has to stay set while strobes are ignored, and then clear only on its own channel's next update. It cannot be watched by reading STATUS, because that read would clear it. The stimulus therefore builds the state step by step: it sets the bits with the channel enabled and running, then stops the run and clears the enables. It observes the held bits through irqOut only, then restarts and updates one channel at a time. A long seeded random phase then mixes limit writes, enable and run changes, strobes and reads against a bench model.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
  localparam int DATA_W    = 8;
  localparam int TACH_W    = 16;
  localparam int NUM_TACH  = 4;
  localparam int NUM_DIODE = 2;
  localparam int ADDR_W    = 5;

  // status bit layout (shared by the enable register)
  localparam int STAT_VOLT   = 0;
  localparam int STAT_RSVD   = 1;
  localparam int STAT_TACH0  = 2;
  localparam int STAT_DIODE0 = STAT_TACH0 + NUM_TACH;
  localparam int STAT_W      = STAT_DIODE0 + NUM_DIODE;

  // register addresses
  localparam int A_CTRL     = 0;
  localparam int A_ENABLE   = 1;
  localparam int A_STATUS   = 2;
  localparam int A_STATUS2  = 3;
  localparam int A_VOLT_RD  = 4;
  localparam int A_VOLT_LO  = 5;
  localparam int A_VOLT_HI  = 6;
  localparam int A_TACH_RD  = 8;
  localparam int A_TACH_MIN = A_TACH_RD + 2 * NUM_TACH;
  localparam int A_DIODE_RD = A_TACH_MIN + 2 * NUM_TACH;
  localparam int A_DIODE_HI = A_DIODE_RD + NUM_DIODE;

  localparam logic [DATA_W-1:0] DIODE_FAULT_CODE = DATA_W'(8'h80);
  localparam logic [STAT_W-1:0] ENABLE_MASK = ~(STAT_W'(1) << STAT_RSVD);

  typedef struct packed {
    logic                                start;
    logic                                irqEn;
    logic [STAT_W-1:0]                   enable;
    logic [DATA_W-1:0]                   voltLo;
    logic [DATA_W-1:0]                   voltHi;
    logic [NUM_TACH-1:0][TACH_W-1:0]     tachMin;
    logic [NUM_DIODE-1:0][DATA_W-1:0]    diodeHi;
  } cfg_t;

  typedef struct packed {
    logic                  updVolt;
    logic [NUM_TACH-1:0]   updTach;
    logic [NUM_DIODE-1:0]  updDiode;
    logic                  clrStatus;
    logic                  clrStatus2;
    logic                  rdEn;
    logic [ADDR_W-1:0]     rdAddr;
  } strobe_t;
endpackage

// File: rtl/hwmon_ctrl.sv
module hwmon_ctrl
  import hwmon_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           hostWrEn,
  input  logic                           hostRdEn,
  input  logic [ADDR_W-1:0]              hostAddr,
  input  logic [DATA_W-1:0]              hostWrData,
  input  logic                           voltStrobe,
  input  logic [NUM_TACH-1:0]            tachStrobe,
  input  logic [NUM_DIODE-1:0]           diodeStrobe,
  output cfg_t                           cfg,
  output strobe_t                        stb
);
  logic                             startQ;
  logic                             irqEnQ;
  logic [STAT_W-1:0]                enableQ;
  logic [DATA_W-1:0]                voltLoQ;
  logic [DATA_W-1:0]                voltHiQ;
  logic [NUM_TACH-1:0][TACH_W-1:0]  tachMinQ;
  logic [NUM_DIODE-1:0][DATA_W-1:0] diodeHiQ;

  function automatic logic wrAt(input int a);
    return hostWrEn && (hostAddr == ADDR_W'(a));
  endfunction

  // scalar configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ  <= 1'b0;
      irqEnQ  <= 1'b0;
      enableQ <= '0;
      voltLoQ <= '0;
      voltHiQ <= '1;
    end else begin
      if (wrAt(A_CTRL)) begin
        startQ <= hostWrData[0];
        irqEnQ <= hostWrData[1];
      end
      if (wrAt(A_ENABLE))  enableQ <= STAT_W'(hostWrData) & ENABLE_MASK;
      if (wrAt(A_VOLT_LO)) voltLoQ <= hostWrData;
      if (wrAt(A_VOLT_HI)) voltHiQ <= hostWrData;
    end
  end

  // per-channel limit registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TACH; i++)  tachMinQ[i] <= '1;
      for (int j = 0; j < NUM_DIODE; j++) diodeHiQ[j] <= DATA_W'(8'h7F);
    end else begin
      for (int i = 0; i < NUM_TACH; i++) begin
        if (wrAt(A_TACH_MIN + 2 * i))     tachMinQ[i][DATA_W-1:0]      <= hostWrData;
        if (wrAt(A_TACH_MIN + 2 * i + 1)) tachMinQ[i][TACH_W-1:DATA_W] <= hostWrData;
      end
      for (int j = 0; j < NUM_DIODE; j++) begin
        if (wrAt(A_DIODE_HI + j)) diodeHiQ[j] <= hostWrData;
      end
    end
  end

  always_comb begin
    cfg.start   = startQ;
    cfg.irqEn   = irqEnQ;
    cfg.enable  = enableQ;
    cfg.voltLo  = voltLoQ;
    cfg.voltHi  = voltHiQ;
    cfg.tachMin = tachMinQ;
    cfg.diodeHi = diodeHiQ;
  end

  // measurement strobes are accepted only while the run control is on
  always_comb begin
    stb.updVolt    = startQ & voltStrobe;
    stb.updTach    = {NUM_TACH{startQ}} & tachStrobe;
    stb.updDiode   = {NUM_DIODE{startQ}} & diodeStrobe;
    stb.clrStatus  = hostRdEn && (hostAddr == ADDR_W'(A_STATUS));
    stb.clrStatus2 = hostRdEn && (hostAddr == ADDR_W'(A_STATUS2));
    stb.rdEn       = hostRdEn;
    stb.rdAddr     = hostAddr;
  end
endmodule

// File: rtl/hwmon_datapath.sv
module hwmon_datapath
  import hwmon_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  cfg_t                           cfg,
  input  strobe_t                        stb,
  input  logic [DATA_W-1:0]              voltSample,
  input  logic [NUM_TACH*TACH_W-1:0]     tachSample,
  input  logic [NUM_DIODE*DATA_W-1:0]    diodeSample,
  input  logic [NUM_DIODE-1:0]           diodeFault,
  output logic [DATA_W-1:0]              rdData,
  output logic [STAT_W-1:0]              statusOut,
  output logic [NUM_DIODE-1:0]           status2Out,
  output logic                           irqOut
);
  logic [DATA_W-1:0]                voltRdQ;
  logic [NUM_TACH-1:0][TACH_W-1:0]  tachRdQ;
  logic [NUM_DIODE-1:0][DATA_W-1:0] diodeRdQ;
  logic [NUM_DIODE-1:0][DATA_W-1:0] diodeVal;
  logic [NUM_TACH-1:0]              tachHit;
  logic [NUM_DIODE-1:0]             overHit;
  logic                             voltHit;
  logic [STAT_W-1:0]                statusQ, statusD, updVec, hitVec, baseVec;
  logic [NUM_DIODE-1:0]             status2Q, status2D, base2, en2;
  logic [DATA_W-1:0]                rdMux;

  // compare incoming samples; the comparison uses the value being latched
  assign voltHit = (voltSample <= cfg.voltLo) || (voltSample > cfg.voltHi);

  for (genvar i = 0; i < NUM_TACH; i++) begin : g_tach
    assign tachHit[i] = tachSample[i*TACH_W +: TACH_W] > cfg.tachMin[i];
  end

  for (genvar j = 0; j < NUM_DIODE; j++) begin : g_diode
    assign diodeVal[j] = diodeFault[j] ? DIODE_FAULT_CODE : diodeSample[j*DATA_W +: DATA_W];
    assign overHit[j]  = $signed(diodeVal[j]) > $signed(cfg.diodeHi[j]);
  end

  // reading registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voltRdQ  <= '0;
      tachRdQ  <= '0;
      diodeRdQ <= '0;
    end else begin
      if (stb.updVolt) voltRdQ <= voltSample;
      for (int i = 0; i < NUM_TACH; i++)
        if (stb.updTach[i]) tachRdQ[i] <= tachSample[i*TACH_W +: TACH_W];
      for (int j = 0; j < NUM_DIODE; j++)
        if (stb.updDiode[j]) diodeRdQ[j] <= diodeVal[j];
    end
  end

  // status update: updated channels take enable-gated sticky value, or 0 when disabled
  always_comb begin
    updVec = '0;
    hitVec = '0;
    updVec[STAT_VOLT] = stb.updVolt;
    hitVec[STAT_VOLT] = voltHit;
    updVec[STAT_TACH0 +: NUM_TACH]   = stb.updTach;
    hitVec[STAT_TACH0 +: NUM_TACH]   = tachHit;
    updVec[STAT_DIODE0 +: NUM_DIODE] = stb.updDiode;
    hitVec[STAT_DIODE0 +: NUM_DIODE] = diodeFault;
    baseVec = stb.clrStatus ? '0 : statusQ;
    statusD = (baseVec & ~updVec) | (updVec & cfg.enable & (baseVec | hitVec));
    statusD[STAT_RSVD] = 1'b0;
    en2      = cfg.enable[STAT_DIODE0 +: NUM_DIODE];
    base2    = stb.clrStatus2 ? '0 : status2Q;
    status2D = (base2 & ~stb.updDiode) | (stb.updDiode & en2 & (base2 | overHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      status2Q <= '0;
    end else begin
      statusQ  <= statusD;
      status2Q <= status2D;
    end
  end

  // host read multiplexer
  always_comb begin
    rdMux = '0;
    case (int'(stb.rdAddr))
      A_CTRL:    rdMux = DATA_W'({cfg.irqEn, cfg.start});
      A_ENABLE:  rdMux = DATA_W'(cfg.enable);
      A_STATUS:  rdMux = DATA_W'(statusQ);
      A_STATUS2: rdMux = DATA_W'(status2Q);
      A_VOLT_RD: rdMux = voltRdQ;
      A_VOLT_LO: rdMux = cfg.voltLo;
      A_VOLT_HI: rdMux = cfg.voltHi;
      default:   rdMux = '0;
    endcase
    for (int i = 0; i < NUM_TACH; i++) begin
      if (int'(stb.rdAddr) == A_TACH_RD + 2 * i)      rdMux = tachRdQ[i][DATA_W-1:0];
      if (int'(stb.rdAddr) == A_TACH_RD + 2 * i + 1)  rdMux = tachRdQ[i][TACH_W-1:DATA_W];
      if (int'(stb.rdAddr) == A_TACH_MIN + 2 * i)     rdMux = cfg.tachMin[i][DATA_W-1:0];
      if (int'(stb.rdAddr) == A_TACH_MIN + 2 * i + 1) rdMux = cfg.tachMin[i][TACH_W-1:DATA_W];
    end
    for (int j = 0; j < NUM_DIODE; j++) begin
      if (int'(stb.rdAddr) == A_DIODE_RD + j) rdMux = diodeRdQ[j];
      if (int'(stb.rdAddr) == A_DIODE_HI + j) rdMux = cfg.diodeHi[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdEn ? rdMux : '0;
  end

  assign statusOut  = statusQ;
  assign status2Out = status2Q;
  assign irqOut     = cfg.irqEn & ((|statusQ) | (|status2Q));
endmodule

// File: rtl/hwmon_limit_status.sv
module hwmon_limit_status
  import hwmon_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWrEn,
  input  logic                        hostRdEn,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWrData,
  output logic [DATA_W-1:0]           hostRdData,
  input  logic                        voltStrobe,
  input  logic [DATA_W-1:0]           voltSample,
  input  logic [NUM_TACH-1:0]         tachStrobe,
  input  logic [NUM_TACH*TACH_W-1:0]  tachSample,
  input  logic [NUM_DIODE-1:0]        diodeStrobe,
  input  logic [NUM_DIODE*DATA_W-1:0] diodeSample,
  input  logic [NUM_DIODE-1:0]        diodeFault,
  output logic                        irqOut
);
  cfg_t                 cfg;
  strobe_t              stb;
  logic [STAT_W-1:0]    statusVec;
  logic [NUM_DIODE-1:0] status2Vec;

  hwmon_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostWrEn    (hostWrEn),
    .hostRdEn    (hostRdEn),
    .hostAddr    (hostAddr),
    .hostWrData  (hostWrData),
    .voltStrobe  (voltStrobe),
    .tachStrobe  (tachStrobe),
    .diodeStrobe (diodeStrobe),
    .cfg         (cfg),
    .stb         (stb)
  );

  hwmon_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfg         (cfg),
    .stb         (stb),
    .voltSample  (voltSample),
    .tachSample  (tachSample),
    .diodeSample (diodeSample),
    .diodeFault  (diodeFault),
    .rdData      (hostRdData),
    .statusOut   (statusVec),
    .status2Out  (status2Vec),
    .irqOut      (irqOut)
  );
endmodule

// File: rtl/hwmon_limit_status_chk.sv
module hwmon_limit_status_chk
  import hwmon_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 irqEn,
  input logic [STAT_W-1:0]    enable,
  input logic [STAT_W-1:0]    status,
  input logic [NUM_DIODE-1:0] status2,
  input logic                 hostRdEn,
  input logic [ADDR_W-1:0]    hostAddr,
  input logic [NUM_DIODE-1:0] diodeStrobe,
  input logic [NUM_DIODE-1:0] diodeFault,
  input logic                 irqOut
);
  logic rdStatus;
  assign rdStatus = hostRdEn && (hostAddr == ADDR_W'(A_STATUS));

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    AST_NO_SET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[b]) |-> $past(enable[b])); // R8
    AST_STICKY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
      (status[b] && enable[b] && !rdStatus) |=> status[b]); // R7
  end

  for (genvar j = 0; j < NUM_DIODE; j++) begin : g_dio
    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (start && diodeStrobe[j] && diodeFault[j] && enable[STAT_DIODE0+j]) |=> status[STAT_DIODE0+j]); // R4
    AST_FAULT_NO_OVER: assert property (@(posedge clk) disable iff (!rstN)
      (start && diodeStrobe[j] && diodeFault[j] && !status2[j]) |=> !status2[j]); // R5
  end

  AST_NO_SET_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ((status & ~$past(status)) == '0)); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    status[STAT_RSVD] == 1'b0); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut); // R12
endmodule

bind hwmon_limit_status hwmon_limit_status_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (cfg.start),
  .irqEn       (cfg.irqEn),
  .enable      (cfg.enable),
  .status      (statusVec),
  .status2     (status2Vec),
  .hostRdEn    (hostRdEn),
  .hostAddr    (hostAddr),
  .diodeStrobe (diodeStrobe),
  .diodeFault  (diodeFault),
  .irqOut      (irqOut)
);

// File: tb/hwmon_limit_status_tb.sv
module hwmon_limit_status_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrEn, hostRdEn;
  logic [4:0]  hostAddr;
  logic [7:0]  hostWrData, hostRdData;
  logic        voltStrobe;
  logic [7:0]  voltSample;
  logic [3:0]  tachStrobe;
  logic [63:0] tachSample;
  logic [1:0]  diodeStrobe, diodeFault;
  logic [15:0] diodeSample;
  logic        irqOut;

  always #10 clk = ~clk; // 50 MHz

  hwmon_limit_status u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .voltStrobe(voltStrobe), .voltSample(voltSample),
    .tachStrobe(tachStrobe), .tachSample(tachSample),
    .diodeStrobe(diodeStrobe), .diodeSample(diodeSample), .diodeFault(diodeFault),
    .irqOut(irqOut)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] lastRd;

  // bench model of the register file
  logic        mStart, mIrqEn;
  logic [7:0]  mEn, mVLo, mVHi, mVRd, mSt;
  logic [1:0]  mSt2;
  logic [15:0] mTMin [4];
  logic [15:0] mTRd  [4];
  logic [7:0]  mDHi  [2];
  logic [7:0]  mDRd  [2];

  task automatic modelReset();
    mStart = 0; mIrqEn = 0; mEn = 0; mVLo = 0; mVHi = 8'hFF; mVRd = 0; mSt = 0; mSt2 = 0;
    for (int i = 0; i < 4; i++) begin mTMin[i] = 16'hFFFF; mTRd[i] = 0; end
    for (int j = 0; j < 2; j++) begin mDHi[j] = 8'h7F; mDRd[j] = 0; end
  endtask

  function automatic logic [7:0] expRead(input int a);
    if (a == 0) return {6'b0, mIrqEn, mStart};
    if (a == 1) return mEn;
    if (a == 2) return mSt;
    if (a == 3) return {6'b0, mSt2};
    if (a == 4) return mVRd;
    if (a == 5) return mVLo;
    if (a == 6) return mVHi;
    if (a >= 8 && a < 16)  return (a % 2 == 0) ? mTRd[(a-8)/2][7:0]  : mTRd[(a-8)/2][15:8];
    if (a >= 16 && a < 24) return (a % 2 == 0) ? mTMin[(a-16)/2][7:0] : mTMin[(a-16)/2][15:8];
    if (a == 24 || a == 25) return mDRd[a-24];
    if (a == 26 || a == 27) return mDHi[a-26];
    return 8'h00;
  endfunction

  function automatic logic expIrq();
    return mIrqEn & ((|mSt) | (|mSt2));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input int a, input logic [7:0] d);
    if (a == 0) begin mStart = d[0]; mIrqEn = d[1]; end
    else if (a == 1) mEn = d & 8'hFD;
    else if (a == 5) mVLo = d;
    else if (a == 6) mVHi = d;
    else if (a >= 16 && a < 24) begin
      if (a % 2 == 0) mTMin[(a-16)/2][7:0] = d; else mTMin[(a-16)/2][15:8] = d;
    end
    else if (a == 26 || a == 27) mDHi[a-26] = d;
  endtask

  // all tasks start and end at a falling edge
  task automatic busWrite(input int a, input logic [7:0] d);
    hostWrEn = 1; hostAddr = 5'(a); hostWrData = d;
    @(negedge clk);
    hostWrEn = 0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input int a, input string tag);
    logic [7:0] e;
    e = expRead(a);
    hostRdEn = 1; hostAddr = 5'(a);
    @(negedge clk);
    hostRdEn = 0;
    lastRd = hostRdData;
    check(hostRdData == e, tag, hostRdData, e);
    if (a == 2) mSt = 0;
    if (a == 3) mSt2 = 0;
  endtask

  task automatic checkIrq(input string tag);
    check(irqOut == expIrq(), tag, irqOut, expIrq());
  endtask

  task automatic strobeVolt(input logic [7:0] v);
    voltStrobe = 1; voltSample = v;
    @(negedge clk);
    voltStrobe = 0;
    if (mStart) begin
      mVRd = v;
      mSt[0] = mEn[0] ? (mSt[0] | ((v <= mVLo) || (v > mVHi))) : 1'b0;
    end
  endtask

  task automatic strobeTach(input int i, input logic [15:0] v);
    tachStrobe[i] = 1; tachSample[i*16 +: 16] = v;
    @(negedge clk);
    tachStrobe = 0;
    if (mStart) begin
      mTRd[i] = v;
      mSt[2+i] = mEn[2+i] ? (mSt[2+i] | (v > mTMin[i])) : 1'b0;
    end
  endtask

  task automatic strobeDiode(input int j, input logic [7:0] v, input logic f);
    logic [7:0] val;
    diodeStrobe[j] = 1; diodeSample[j*8 +: 8] = v; diodeFault[j] = f;
    @(negedge clk);
    diodeStrobe = 0; diodeFault = 0;
    if (mStart) begin
      val = f ? 8'h80 : v;
      mDRd[j] = val;
      mSt[6+j] = mEn[6+j] ? (mSt[6+j] | f) : 1'b0;
      mSt2[j]  = mEn[6+j] ? (mSt2[j] | ($signed(val) > $signed(mDHi[j]))) : 1'b0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    hostWrEn = 0; hostRdEn = 0; hostAddr = 0; hostWrData = 0;
    voltStrobe = 0; voltSample = 0; tachStrobe = 0; tachSample = 0;
    diodeStrobe = 0; diodeSample = 0; diodeFault = 0;
    modelReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    checkIrq("R1 irq after reset");
    busRead(2, "R1 status reset");
    busRead(3, "R1 status2 reset");
    busRead(0, "R1 ctrl reset");
    busRead(6, "R1 volt high limit reset");
    busRead(21, "R1 tach min reset");
    busRead(26, "R1 diode limit reset");

    busWrite(0, 8'h03);
    busWrite(1, 8'hFF);
    busRead(1, "R6 enable reserved bit");
    check(lastRd == 8'hFD, "R6 enable literal", lastRd, 8'hFD);

    // R2 voltage window boundaries
    busWrite(5, 8'd10); busWrite(6, 8'd200);
    strobeVolt(8'd11);  busRead(2, "R2 above low limit");
    strobeVolt(8'd10);  busRead(2, "R2 equal low limit");
    check(lastRd == 8'h01, "R2 equal low literal", lastRd, 8'h01);
    busRead(2, "R7 read cleared");
    strobeVolt(8'd200); busRead(2, "R2 equal high limit");
    strobeVolt(8'd201); strobeVolt(8'd50);
    busRead(2, "R7 sticky after good sample");
    check(lastRd == 8'h01, "R7 sticky literal", lastRd, 8'h01);
    busRead(4, "R13 volt reading");

    // R3 tachometer 1 minimum
    busWrite(19, 8'h12); busWrite(18, 8'h34);
    strobeTach(1, 16'h1234); busRead(2, "R3 tach equal minimum");
    strobeTach(1, 16'h1235); busRead(2, "R3 tach above minimum");
    check(lastRd == 8'h08, "R3 tach literal", lastRd, 8'h08);
    busRead(10, "R3 tach reading lsb"); busRead(11, "R3 tach reading msb");

    // R4 / R5 diode fault and over-temperature
    strobeDiode(0, 8'h10, 1'b1);
    busRead(24, "R4 fault code loaded");
    check(lastRd == 8'h80, "R4 fault code literal", lastRd, 8'h80);
    busRead(2, "R4 fault status");
    busRead(3, "R5 fault gives no over-temp");
    busWrite(27, 8'h20);
    strobeDiode(1, 8'h21, 1'b0); busRead(3, "R5 over limit");
    check(lastRd == 8'h02, "R5 over literal", lastRd, 8'h02);
    strobeDiode(1, 8'h20, 1'b0); busRead(3, "R5 equal limit");
    strobeDiode(1, 8'hF0, 1'b0); busRead(3, "R5 negative reading");

    // R6 writes to status ignored; R12 gating
    strobeVolt(8'd0);
    busWrite(2, 8'h00);
    checkIrq("R6 status write ignored irq");
    busWrite(0, 8'h01); checkIrq("R12 irq gated off");
    busWrite(0, 8'h03); checkIrq("R12 irq back on");
    busWrite(2, 8'hFF);
    busRead(2, "R6 status after writes");

    // R8 disabled channel never sets
    busWrite(1, 8'hFC);
    strobeVolt(8'd0);
    checkIrq("R8 irq stays low");
    busRead(2, "R8 disabled volt");

    // R9 / R10 / R11 deferred clear
    busWrite(1, 8'hFD);
    strobeVolt(8'd0);
    strobeDiode(1, 8'h21, 1'b0);
    strobeDiode(1, 8'h00, 1'b1);
    busWrite(0, 8'h02);
    busWrite(1, 8'h7C);
    checkIrq("R9 bit held after disable");
    strobeVolt(8'd50);
    strobeDiode(1, 8'h00, 1'b0);
    checkIrq("R10 stopped strobes ignored");
    check(irqOut == 1'b1, "R9 held literal", irqOut, 1);
    busRead(4, "R10 volt reading unchanged");
    busRead(25, "R10 diode reading unchanged");
    busWrite(0, 8'h03);
    strobeVolt(8'd50);
    checkIrq("R9 other channel still set");
    check(irqOut == 1'b1, "R9 other channel literal", irqOut, 1);
    strobeDiode(1, 8'h00, 1'b0);
    checkIrq("R11 diode disable clears both");
    check(irqOut == 1'b0, "R11 irq literal", irqOut, 0);
    busRead(3, "R11 status2 cleared");
    busRead(2, "R9 status cleared");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) begin
        int a;
        logic [7:0] d;
        a = $urandom_range(0, 27);
        d = 8'($urandom);
        if (a == 0) d = {6'b0, 1'($urandom), 1'($urandom_range(0, 7) != 0)};
        busWrite(a, d);
      end else if (op < 5) begin
        busRead($urandom_range(0, 31), "R13 random read");
      end else if (op < 7) begin
        strobeVolt(8'($urandom));
      end else if (op < 8) begin
        strobeTach($urandom_range(0, 3), 16'($urandom));
      end else begin
        strobeDiode($urandom_range(0, 1), 8'($urandom), $urandom_range(0, 3) == 0);
      end
      checkIrq("R12 random irq");
    end

    summary();
    $finish;
  end
endmodule